// File: doc/BRIEF.md
# Serial Bit-Stream Save EEPROM Controller

This block sits on the host side of a small serial save EEPROM whose only link is a data port that moves one bit per transfer unit. A single command strobe starts a 64-bit block access. For a read, the block sends a short request stream and then gathers the response stream into a 64-bit word. For a write, it sends the request with the data inline and then keeps sampling the device until the device signals that its internal programming is finished.

Two part sizes are supported and chosen per command by a size select: a small part with a 6-bit block address and a large part with a 14-bit block address. Both directions use a valid/ready handshake on 16-bit units. Only bit 0 of a unit carries information. The write completion poll has a bounded wait. If the device never signals ready, the block raises a one-cycle timeout error and goes back to idle.

Top module: `bitser_eeprom_ctrl`

## Requirements
- R1: A read request is sent as the bits 1,1, then the block address most significant bit first, then one 0 stop bit. The request is 9 units long for the small part (cmd_large=0) and 17 units long for the large part (cmd_large=1).
- R2: A write request is sent as the bits 1,0, then the address most significant bit first, then the 64 data bits with cmd_wdata[63] first and cmd_wdata[0] last, then one 0 stop bit. The request is 73 units long for the small part and 81 units long for the large part.
- R3: In small mode only cmd_addr[5:0] is sent. cmd_addr[13:6] has no effect on the request.
- R4: Each sent unit carries its stream bit in tx_data[0], and tx_data[15:1] is zero. A unit is held stable until tx_ready accepts it.
- R5: After a read request, rx_ready stays high until 68 units have been accepted. The first 4 units are discarded. The next 64 units fill rd_data from bit 63 down to bit 0. Only rx_data[0] of each unit is used.
- R6: done is high for exactly one cycle. That cycle is the one after the last response unit is accepted; busy is low in it and rd_data holds the new block.
- R7: After a write request, rx_ready stays high while the device is polled. Units with rx_data[0]=0 are ignored. done pulses in the cycle after a unit with rx_data[0]=1 is accepted.
- R8: If no ready unit arrives within TIMEOUT_CYC poll cycles, timeout_err pulses for one cycle without done, and the block returns to idle. A ready unit in the last poll cycle still counts as success.
- R9: A cmd_valid while busy is high is ignored and does not disturb the transfer in progress.
- R10: During and after reset, busy, done, timeout_err, tx_valid and rx_ready are low and rd_data is zero.
- R11: busy goes high in the cycle after a command is accepted and stays high until the cycle in which done or timeout_err is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, taken when idle |
| cmd_write | input | 1 | 1 = write block, 0 = read block |
| cmd_large | input | 1 | 1 = 14-bit address part, 0 = 6-bit address part |
| cmd_addr | input | 14 | Block address |
| cmd_wdata | input | 64 | Write block, bit 63 sent first |
| tx_valid | output | 1 | Outgoing unit valid |
| tx_ready | input | 1 | Outgoing unit accepted |
| tx_data | output | 16 | Outgoing unit, stream bit in bit 0 |
| rx_valid | input | 1 | Incoming unit valid |
| rx_ready | output | 1 | Controller takes incoming units |
| rx_data | input | 16 | Incoming unit, only bit 0 used |
| rd_data | output | 64 | Last block read |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Access in progress |
| timeout_err | output | 1 | One-cycle write-poll timeout pulse |

## Verification
The device's ready answer and the expiry of the poll window can land in the same cycle. The bench counts the cycles in which rx_ready is high after a write request. It places the ready unit exactly on poll cycle TIMEOUT_CYC, which must give done and no timeout. It places the ready unit one cycle later, which must give timeout_err and no done. Random poll delays on both sides of the limit are checked the same way: the bench compares the counted number of poll cycles with the smaller of the delay and the limit.

// File: rtl/bitser_eeprom_ctrl.sv
module bitser_eeprom_ctrl #(
  parameter int UNIT_W      = 16,
  parameter int DATA_W      = 64,
  parameter int AW_SMALL    = 6,
  parameter int AW_LARGE    = 14,
  parameter int SKIP_BITS   = 4,
  parameter int TIMEOUT_CYC = 2_500_000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic                cmd_write,
  input  logic                cmd_large,
  input  logic [AW_LARGE-1:0] cmd_addr,
  input  logic [DATA_W-1:0]   cmd_wdata,
  output logic                tx_valid,
  input  logic                tx_ready,
  output logic [UNIT_W-1:0]   tx_data,
  input  logic                rx_valid,
  output logic                rx_ready,
  input  logic [UNIT_W-1:0]   rx_data,
  output logic [DATA_W-1:0]   rd_data,
  output logic                done,
  output logic                busy,
  output logic                timeout_err
);
  localparam int FRAME_W = 2 + AW_LARGE + DATA_W + 1;
  localparam int RESP_N  = SKIP_BITS + DATA_W;
  localparam int CW      = $clog2((FRAME_W > RESP_N ? FRAME_W : RESP_N) + 1);
  localparam int TW      = $clog2(TIMEOUT_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_RECV, S_POLL} st_t;

  st_t                st;
  logic               is_wr;
  logic [FRAME_W-1:0] sh, frame;
  logic [CW-1:0]      cnt, last, flen;
  logic [TW-1:0]      pcnt;
  logic [DATA_W-1:0]  acc;
  logic               unused_rx_hi;

  assign unused_rx_hi = ^rx_data[UNIT_W-1:1];

  always_comb begin
    frame = '0;
    frame[FRAME_W-1 -: 2] = cmd_write ? 2'b10 : 2'b11;
    if (cmd_large) begin
      frame[FRAME_W-3 -: AW_LARGE] = cmd_addr;
      if (cmd_write) frame[FRAME_W-3-AW_LARGE -: DATA_W] = cmd_wdata;
      flen = CW'(2 + AW_LARGE + 1) + (cmd_write ? CW'(DATA_W) : '0);
    end else begin
      frame[FRAME_W-3 -: AW_SMALL] = cmd_addr[AW_SMALL-1:0];
      if (cmd_write) frame[FRAME_W-3-AW_SMALL -: DATA_W] = cmd_wdata;
      flen = CW'(2 + AW_SMALL + 1) + (cmd_write ? CW'(DATA_W) : '0);
    end
  end

  assign busy     = (st != S_IDLE);
  assign tx_valid = (st == S_SEND);
  assign tx_data  = {{(UNIT_W-1){1'b0}}, sh[FRAME_W-1]};
  assign rx_ready = (st == S_RECV) || (st == S_POLL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      is_wr       <= 1'b0;
      sh          <= '0;
      cnt         <= '0;
      last        <= '0;
      pcnt        <= '0;
      acc         <= '0;
      rd_data     <= '0;
      done        <= 1'b0;
      timeout_err <= 1'b0;
    end else begin
      done        <= 1'b0;
      timeout_err <= 1'b0;
      case (st)
        S_IDLE: if (cmd_valid) begin
          sh    <= frame;
          last  <= flen - CW'(1);
          cnt   <= '0;
          is_wr <= cmd_write;
          st    <= S_SEND;
        end
        S_SEND: if (tx_ready) begin
          sh  <= sh << 1;
          cnt <= cnt + CW'(1);
          if (cnt == last) begin
            cnt  <= '0;
            pcnt <= '0;
            st   <= is_wr ? S_POLL : S_RECV;
          end
        end
        S_RECV: if (rx_valid) begin
          cnt <= cnt + CW'(1);
          if (cnt >= CW'(SKIP_BITS)) acc <= {acc[DATA_W-2:0], rx_data[0]};
          if (cnt == CW'(RESP_N - 1)) begin
            rd_data <= {acc[DATA_W-2:0], rx_data[0]};
            done    <= 1'b1;
            st      <= S_IDLE;
          end
        end
        S_POLL: begin
          if (rx_valid && rx_data[0]) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end else if (pcnt == TW'(TIMEOUT_CYC - 1)) begin
            timeout_err <= 1'b1;
            st          <= S_IDLE;
          end else begin
            pcnt <= pcnt + TW'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_first_bit_one_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> tx_valid && tx_data[0]);
  assert_hold_unit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));
  assert_excl_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && timeout_err));
  assert_timeout_from_poll_R8: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |-> $past(rx_ready) && !busy);
  assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cmd_valid && !tx_valid |=> !tx_valid);
endmodule

// File: tb/sim_bitser_eeprom_ctrl.sv
module sim_bitser_eeprom_ctrl;
  localparam int TO = 40;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cmd_valid = 0, cmd_write = 0, cmd_large = 0;
  logic [13:0] cmd_addr = '0;
  logic [63:0] cmd_wdata = '0;
  logic        tx_valid, tx_ready = 0, rx_valid = 0, rx_ready;
  logic [15:0] tx_data, rx_data = '0;
  logic [63:0] rd_data;
  logic        done, busy, timeout_err;

  int checks = 0, errors = 0;
  bit ended = 0;

  always #2 clk = ~clk;

  bitser_eeprom_ctrl #(.TIMEOUT_CYC(TO)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_large(cmd_large), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rd_data(rd_data), .done(done), .busy(busy), .timeout_err(timeout_err));

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int req_len(input bit w, input bit lg);
    return 3 + (lg ? 14 : 6) + (w ? 64 : 0);
  endfunction

  function automatic bit req_bit(input int i, input bit w, input bit lg,
                                 input logic [13:0] a, input logic [63:0] d);
    int aw = lg ? 14 : 6;
    if (i == 0) return 1'b1;
    if (i == 1) return !w;
    if (i < 2 + aw) return a[aw - 1 - (i - 2)];
    if (w && i < 2 + aw + 64) return d[63 - (i - 2 - aw)];
    return 1'b0;
  endfunction

  task automatic noise();
    cmd_valid = ($urandom % 4) == 0;
    cmd_write = $urandom;
    cmd_large = $urandom;
    cmd_addr  = 14'($urandom);
  endtask

  task automatic run(input bit w, input bit lg, input logic [13:0] a,
                     input logic [63:0] d, input int delay);
    int n = 0, bad = 0, idx = 0, k = 0, len = req_len(w, lg);
    bit upper = 0;
    logic [63:0] exp_rd = {$urandom, $urandom};
    @(negedge clk);
    cmd_valid = 1; cmd_write = w; cmd_large = lg; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 0;
    check(busy && tx_valid, "R11 busy after accept", {62'b0, busy, tx_valid}, 64'h3);
    while (tx_valid) begin
      tx_ready = ($urandom % 3) != 0;
      if (tx_data[15:1] != 0) upper = 1;
      if (tx_ready) begin
        if (n >= len || tx_data[0] != req_bit(n, w, lg, a, d)) bad++;
        n++;
      end
      noise();
      @(posedge clk);
      @(negedge clk);
      cmd_valid = 0;
    end
    tx_ready = 0;
    check(n == len, w ? "R2 request length" : "R1 request length", 64'(n), 64'(len));
    check(bad == 0, w ? "R2 request bits (R3 small address)" : "R1 request bits (R3 small address)",
          64'(bad), 64'd0);
    check(!upper, "R4 upper unit bits zero", 64'(upper), 64'd0);
    while (rx_ready) begin
      k++;
      if (!w) begin
        rx_valid = ($urandom % 3) != 0;
        rx_data  = 16'($urandom);
        rx_data[0] = (idx < 4) ? 1'($urandom) : exp_rd[63 - (idx - 4)];
      end else if (k == delay) begin
        rx_valid = 1; rx_data = 16'($urandom) | 16'h1;
      end else begin
        rx_valid = $urandom; rx_data = 16'($urandom) & 16'hFFFE;
      end
      noise();
      @(posedge clk);
      if (rx_valid) idx++;
      @(negedge clk);
      cmd_valid = 0;
      rx_valid = 0;
    end
    if (!w) begin
      check(idx == 68, "R5 response units", 64'(idx), 64'd68);
      check(rd_data == exp_rd, "R5 read data packing", rd_data, exp_rd);
      check(done && !busy && !timeout_err, "R6 done with busy low", {61'b0, done, busy, timeout_err}, 64'h4);
    end else if (delay <= TO) begin
      check(k == delay, "R7 poll cycles", 64'(k), 64'(delay));
      check(done && !timeout_err && !busy, "R7 write done", {61'b0, done, busy, timeout_err}, 64'h4);
    end else begin
      check(k == TO, "R8 poll window", 64'(k), 64'(TO));
      check(timeout_err && !done && !busy, "R8 timeout", {61'b0, done, busy, timeout_err}, 64'h1);
    end
    @(negedge clk);
    check(!done && !timeout_err && !busy, "R6 R9 single pulse and no stray command",
          {61'b0, done, busy, timeout_err}, 64'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    check(!busy && !done && !timeout_err && !tx_valid && !rx_ready && rd_data == 0,
          "R10 reset state", {59'b0, busy, done, timeout_err, tx_valid, rx_ready}, 64'h0);
    rst_n = 1;
    run(0, 0, 14'h3FFF, 64'h0, 0);
    run(0, 1, 14'h2A5C, 64'h0, 0);
    run(1, 0, 14'h3FC0, 64'h0123_4567_89AB_CDEF, 1);
    run(1, 1, 14'h1234, 64'hFEDC_BA98_7654_3210, TO);
    run(1, 1, 14'h0001, 64'hFFFF_0000_FFFF_0000, TO + 1);
    run(1, 0, 14'h0015, 64'h8000_0000_0000_0001, 3);
    for (int t = 0; t < 40; t++) begin
      logic [63:0] d = {$urandom, $urandom};
      int dl = 1 + ($urandom % (TO + 6));
      run(1'($urandom), 1'($urandom), 14'($urandom), d, dl);
    end
    ended = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule